// File: doc/BRIEF.md
# Frame-Buffer Read Address Sequencer for a Display Pixel FIFO

This block generates the byte addresses a display controller uses to fetch 16-bit pixel words from memory into its pixel FIFO. It reads from one frame buffer, or from two buffers in turn, and walks each buffer from its top address to its bottom address in steps of two bytes. The bottom address is inclusive: the word at the bottom address is fetched, and only then does the address wrap. In single-buffer mode it wraps back to the top of the first buffer. In two-buffer mode the first buffer hands over to the second, and the second hands back to the first, with no end to the alternation.

Each fetch uses a request/acknowledge handshake with a memory port. The block keeps the request and the address steady until the port acknowledges the fetch. If the port reports a bus error or a time-out, the block stops requesting, raises a sticky fault flag and pulses an interrupt for one cycle. It leaves that fault state only when the run enable is removed. The buffer bounds and the mode are captured only while the enable is low, so software must stop the block before it changes the configuration.

Top module: `lcd_fb_addr_gen`

## Requirements
- R1: After a synchronous reset, `rd_req`, `fault_flag`, `fault_irq` and `frame_end` are 0 and `rd_addr` is 0.
- R2: In the first cycle after a clock edge that samples `run_en` high while the block is idle, `rd_req` is 1 and `rd_addr` equals the captured `f1_top`.
- R3: When a fetch is acknowledged and `rd_addr` is not the bottom of the active buffer, the next request carries `rd_addr + 2`.
- R4: In single-buffer mode (`two_buf` = 0), after the fetch at `f1_bot` is acknowledged, the next request carries `f1_top`.
- R5: In two-buffer mode (`two_buf` = 1), after the fetch at `f1_bot` the next request carries `f2_top`. After the fetch at `f2_bot` the next request carries `f1_top`.
- R6: While a request is waiting for its acknowledge, `rd_req` stays 1 and `rd_addr` does not change.
- R7: `frame_end` is 1 only in a cycle where a fetch at the active buffer's bottom address is acknowledged without an error or time-out.
- R8: A bus error or time-out during a request takes priority over an acknowledge in the same cycle. From the next cycle, `rd_req` is 0, `fault_flag` is 1, and `fault_irq` is 1 for exactly one cycle.
- R9: `fault_flag` stays 1 while `run_en` is high. One cycle after `run_en` is sampled low, `fault_flag` is 0. A later enable restarts the sequence at `f1_top`.
- R10: If `run_en` falls while a request is outstanding, the request stays asserted until it is acknowledged. After that, no new request is issued.
- R11: Changes to the bounds and to `two_buf` while `run_en` is high have no effect. The values present while `run_en` was last low are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; configuration is captured while low |
| two_buf | input | 1 | 1 = two alternating buffers, 0 = one buffer |
| f1_top | input | ADDR_W | First buffer top byte address |
| f1_bot | input | ADDR_W | First buffer bottom byte address (inclusive) |
| f2_top | input | ADDR_W | Second buffer top byte address |
| f2_bot | input | ADDR_W | Second buffer bottom byte address (inclusive) |
| rd_req | output | 1 | Fetch request to the memory port |
| rd_ack | input | 1 | Fetch acknowledge from the memory port |
| rd_buserr | input | 1 | Bus error reported for the current fetch |
| rd_tmo | input | 1 | Time-out reported for the current fetch |
| rd_addr | output | ADDR_W | Byte address of the current fetch |
| frame_end | output | 1 | Bottom-of-buffer fetch accepted this cycle |
| fault_flag | output | 1 | Sticky fault indication |
| fault_irq | output | 1 | One-cycle fault interrupt pulse |

## Verification
Several properties are checked on every cycle: the request and address stay stable until the acknowledge, the address steps by two off the bottom, the first address after a start is the first buffer's top, a fault drops the request, the fault interrupt lasts one cycle, the fault flag stays set until the enable is removed, and the configuration stays frozen while enabled. The exact address orderings across the wrap in both modes, the timing of `frame_end`, the drain of an outstanding request, and the use of stale configuration after mid-run writes can only be shown by the bench. The bench sweeps buffer lengths in both modes with varied acknowledge delays and compares every fetch address against an arithmetic model.

// File: rtl/lcdag_pkg.sv
package lcdag_pkg;

    // Fixed transfer width: 16-bit words on a byte-addressed bus
    localparam int unsigned WORD_STEP = 2;

    // Index of each buffer bound in the captured bound array
    localparam int unsigned BI_TOP1 = 0;
    localparam int unsigned BI_BOT1 = 1;
    localparam int unsigned BI_TOP2 = 2;
    localparam int unsigned BI_BOT2 = 3;
    localparam int unsigned N_BOUNDS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_FAULT = 2'd2
    } rd_state_e;

    typedef enum logic {
        FR_ONE = 1'b0,
        FR_TWO = 1'b1
    } frame_e;

    // Buffer that follows a completed bottom fetch
    function automatic frame_e next_frame(frame_e cur, logic dual);
        if (!dual) return FR_ONE;
        return (cur == FR_ONE) ? FR_TWO : FR_ONE;
    endfunction

    // Index of the top bound for a buffer
    function automatic int unsigned top_idx(frame_e fr);
        return (fr == FR_ONE) ? BI_TOP1 : BI_TOP2;
    endfunction

    // Index of the bottom bound for a buffer
    function automatic int unsigned bot_idx(frame_e fr);
        return (fr == FR_ONE) ? BI_BOT1 : BI_BOT2;
    endfunction

endpackage

// File: rtl/lcdag_cfg_latch.sv
module lcdag_cfg_latch
    import lcdag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             run_en,
    input  logic                             dual_in,
    input  logic [N_BOUNDS-1:0][ADDR_W-1:0]  bounds_in,
    output logic                             dual_q,
    output logic [N_BOUNDS-1:0][ADDR_W-1:0]  bounds_q
);

    // Mode bit follows its input only while stopped
    always_ff @(posedge clk) begin
        if (rst)          dual_q <= 1'b0;
        else if (!run_en) dual_q <= dual_in;
    end

    // One capture register per buffer bound
    for (genvar gi = 0; gi < N_BOUNDS; gi++) begin : g_bound
        always_ff @(posedge clk) begin
            if (rst)          bounds_q[gi] <= '0;
            else if (!run_en) bounds_q[gi] <= bounds_in[gi];
        end
    end

    // R11: nothing captured moves while running
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        run_en |=> ($stable(bounds_q) && $stable(dual_q)));

endmodule

// File: rtl/lcdag_addr_seq.sv
module lcdag_addr_seq
    import lcdag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             advance,
    input  logic                             dual,
    input  logic [N_BOUNDS-1:0][ADDR_W-1:0]  bounds,
    output logic [ADDR_W-1:0]                addr,
    output logic                             at_bottom
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_STEP);

    frame_e             frame_q;
    frame_e             frame_nx;
    logic [ADDR_W-1:0]  addr_nx;

    assign at_bottom = (addr == bounds[bot_idx(frame_q)]);

    always_comb begin
        frame_nx = frame_q;
        addr_nx  = addr;
        if (start) begin
            frame_nx = FR_ONE;
            addr_nx  = bounds[BI_TOP1];
        end else if (advance) begin
            if (at_bottom) begin
                frame_nx = next_frame(frame_q, dual);
                addr_nx  = bounds[top_idx(frame_nx)];
            end else begin
                addr_nx  = addr + STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= FR_ONE;
            addr    <= '0;
        end else begin
            frame_q <= frame_nx;
            addr    <= addr_nx;
        end
    end

    // R2: a start always lands on the first buffer's top
    p_start_top_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (addr == $past(bounds[BI_TOP1])));

    // R6: without a start or accepted fetch the address holds
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!start && !advance) |=> $stable(addr));

    // R3: off the bottom boundary the address moves one word
    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && !at_bottom) |=> (addr == $past(addr) + STEP));

endmodule

// File: rtl/lcdag_rd_fsm.sv
module lcdag_rd_fsm
    import lcdag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic ack,
    input  logic bus_err,
    input  logic tmo,
    output logic req,
    output logic start,
    output logic advance,
    output logic fault_flag,
    output logic fault_irq
);

    rd_state_e state_q;
    rd_state_e state_nx;
    logic      fault_in;
    logic      fault_hit;

    assign fault_in  = bus_err | tmo;
    assign req       = (state_q == ST_REQ);
    assign start     = (state_q == ST_IDLE) && run_en;
    assign fault_hit = req && fault_in;
    assign advance   = req && ack && !fault_in;
    assign fault_flag = (state_q == ST_FAULT);

    always_comb begin
        state_nx = state_q;
        case (state_q)
            ST_IDLE:  if (run_en) state_nx = ST_REQ;
            ST_REQ: begin
                if (fault_hit)    state_nx = ST_FAULT;
                else if (advance) state_nx = run_en ? ST_REQ : ST_IDLE;
            end
            ST_FAULT: if (!run_en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fault_irq <= 1'b0;
        end else begin
            state_q   <= state_nx;
            fault_irq <= fault_hit;
        end
    end

    // R6: an unanswered request is not withdrawn
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && !fault_in) |=> req);

    // R8: a fault drops the request and raises the flag
    p_fault_entry_r8: assert property (@(posedge clk) disable iff (rst)
        (req && fault_in) |=> (fault_flag && !req && fault_irq));

    // R8: interrupt is a single-cycle pulse
    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        fault_irq |=> !fault_irq);

    // R9: the flag is sticky while enabled
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && run_en) |=> (fault_flag && !req));

    // R9: removing the enable clears the flag
    p_fault_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (fault_flag && !run_en) |=> !fault_flag);

    // R10: a drained request is not followed by another
    p_drain_r10: assert property (@(posedge clk) disable iff (rst)
        (advance && !run_en) |=> !req);

endmodule

// File: rtl/lcd_fb_addr_gen.sv
module lcd_fb_addr_gen
    import lcdag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              two_buf,
    input  logic [ADDR_W-1:0] f1_top,
    input  logic [ADDR_W-1:0] f1_bot,
    input  logic [ADDR_W-1:0] f2_top,
    input  logic [ADDR_W-1:0] f2_bot,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic              rd_buserr,
    input  logic              rd_tmo,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              frame_end,
    output logic              fault_flag,
    output logic              fault_irq
);

    logic [N_BOUNDS-1:0][ADDR_W-1:0] bounds_raw;
    logic [N_BOUNDS-1:0][ADDR_W-1:0] bounds_cap;
    logic                            dual_cap;
    logic                            seq_start;
    logic                            seq_adv;
    logic                            seq_at_bot;

    always_comb begin
        bounds_raw          = '0;
        bounds_raw[BI_TOP1] = f1_top;
        bounds_raw[BI_BOT1] = f1_bot;
        bounds_raw[BI_TOP2] = f2_top;
        bounds_raw[BI_BOT2] = f2_bot;
    end

    lcdag_cfg_latch #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .dual_in   (two_buf),
        .bounds_in (bounds_raw),
        .dual_q    (dual_cap),
        .bounds_q  (bounds_cap)
    );

    lcdag_rd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .ack        (rd_ack),
        .bus_err    (rd_buserr),
        .tmo        (rd_tmo),
        .req        (rd_req),
        .start      (seq_start),
        .advance    (seq_adv),
        .fault_flag (fault_flag),
        .fault_irq  (fault_irq)
    );

    lcdag_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (seq_start),
        .advance   (seq_adv),
        .dual      (dual_cap),
        .bounds    (bounds_cap),
        .addr      (rd_addr),
        .at_bottom (seq_at_bot)
    );

    // R7: end of buffer marks an accepted bottom fetch
    assign frame_end = seq_adv && seq_at_bot;

    // R7: no frame end while a fault is being reported
    p_fend_clean_r7: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (rd_req && !rd_buserr && !rd_tmo));

endmodule

// File: tb/lcd_fb_addr_gen_bench.sv
module lcd_fb_addr_gen_bench;

    localparam int unsigned AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          two_buf = 1'b0;
    logic [AW-1:0] f1_top = '0, f1_bot = '0, f2_top = '0, f2_bot = '0;
    logic          rd_req;
    logic          rd_ack = 1'b0;
    logic          rd_buserr = 1'b0;
    logic          rd_tmo = 1'b0;
    logic [AW-1:0] rd_addr;
    logic          frame_end;
    logic          fault_flag;
    logic          fault_irq;

    int n_cmp  = 0;
    int n_bad  = 0;
    int wait_k = 0;

    always #5 clk = ~clk;

    lcd_fb_addr_gen #(.ADDR_W(AW)) u_lcd_fb_addr_gen (
        .clk(clk), .rst(rst), .run_en(run_en), .two_buf(two_buf),
        .f1_top(f1_top), .f1_bot(f1_bot), .f2_top(f2_top), .f2_bot(f2_bot),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_buserr(rd_buserr), .rd_tmo(rd_tmo),
        .rd_addr(rd_addr), .frame_end(frame_end),
        .fault_flag(fault_flag), .fault_irq(fault_irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(logic dual, logic [AW-1:0] t1, logic [AW-1:0] b1,
                           logic [AW-1:0] t2, logic [AW-1:0] b2);
        two_buf = dual; f1_top = t1; f1_bot = b1; f2_top = t2; f2_bot = b2;
    endtask

    // Enable and check the first request (R2)
    task automatic go(logic [AW-1:0] t1);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check("R2 req", 32'(rd_req), 1);
        check("R2 addr", 32'(rd_addr), 32'(t1));
    endtask

    // One fetch with a few wait cycles before the acknowledge
    task automatic xfer(string tag, logic [AW-1:0] exp, logic is_bot);
        int w;
        w = wait_k % 3;
        wait_k++;
        for (int i = 0; i < w; i++) begin
            check("R6 req held", 32'(rd_req), 1);
            check("R6 addr held", 32'(rd_addr), 32'(exp));
            @(negedge clk);
        end
        check({tag, " req"}, 32'(rd_req), 1);
        check({tag, " addr"}, 32'(rd_addr), 32'(exp));
        rd_ack = 1'b1;
        #1;
        check("R7 frame_end", 32'(frame_end), 32'(is_bot));
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    // Drop the enable with a request outstanding, drain it (R10)
    task automatic stop_drain(logic [AW-1:0] exp, logic is_bot);
        run_en = 1'b0;
        xfer("R10 drain", exp, is_bot);
        check("R10 no new req", 32'(rd_req), 0);
        @(negedge clk);
        check("R10 still idle", 32'(rd_req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] t1, b1, t2, b2;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 req", 32'(rd_req), 0);
        check("R1 addr", 32'(rd_addr), 0);
        check("R1 flag", 32'(fault_flag), 0);
        check("R1 irq", 32'(fault_irq), 0);
        check("R1 frame_end", 32'(frame_end), 0);
        rst = 1'b0;

        // Sweep buffer lengths in both modes, two laps each
        for (int dual = 0; dual < 2; dual++) begin
            for (int n1 = 1; n1 <= 4; n1++) begin
                for (int n2 = 1; n2 <= 3; n2++) begin
                    t1 = AW'(16'h0100 + 16 * n1);
                    b1 = t1 + AW'(2 * (n1 - 1));
                    t2 = b1 + AW'(2 + 4 * n2);
                    b2 = t2 + AW'(2 * (n2 - 1));
                    set_cfg(dual[0], t1, b1, t2, b2);
                    go(t1);
                    for (int lap = 0; lap < 2; lap++) begin
                        for (int k = 0; k < n1; k++)
                            xfer((k == 0) ? ((lap == 0) ? "R2" : (dual != 0 ? "R5" : "R4")) : "R3",
                                 t1 + AW'(2 * k), k == n1 - 1);
                        if (dual != 0)
                            for (int k = 0; k < n2; k++)
                                xfer((k == 0) ? "R5" : "R3", t2 + AW'(2 * k), k == n2 - 1);
                    end
                    stop_drain(t1, n1 == 1);
                end
            end
        end

        // R11: writes during a run are ignored
        set_cfg(1'b0, 16'h0200, 16'h0204, 16'h0300, 16'h0302);
        go(16'h0200);
        set_cfg(1'b1, 16'h0400, 16'h0402, 16'h0500, 16'h0502);
        for (int k = 0; k < 3; k++) xfer("R11 stale cfg", AW'(16'h0200 + 2 * k), k == 2);
        xfer("R11 stale mode", 16'h0200, 1'b0);
        stop_drain(16'h0202, 1'b0);
        go(16'h0400);
        xfer("R11 new cfg", 16'h0400, 1'b0);
        xfer("R11 new cfg", 16'h0402, 1'b1);
        xfer("R11 new mode", 16'h0500, 1'b0);
        stop_drain(16'h0502, 1'b1);

        // R8/R9: bus error at the bottom address, with acknowledge in the same cycle
        set_cfg(1'b0, 16'h0600, 16'h0602, 16'h0700, 16'h0700);
        go(16'h0600);
        xfer("R3", 16'h0600, 1'b0);
        rd_buserr = 1'b1; rd_ack = 1'b1;
        #1;
        check("R8 err beats ack frame_end", 32'(frame_end), 0);
        @(negedge clk);
        rd_buserr = 1'b0; rd_ack = 1'b0;
        check("R8 req dropped", 32'(rd_req), 0);
        check("R8 flag set", 32'(fault_flag), 1);
        check("R8 irq pulse", 32'(fault_irq), 1);
        @(negedge clk);
        check("R8 irq one cycle", 32'(fault_irq), 0);
        rd_ack = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 flag sticky", 32'(fault_flag), 1);
        check("R8 no req after fault", 32'(rd_req), 0);
        rd_ack = 1'b0;
        run_en = 1'b0;
        @(negedge clk);
        check("R9 flag cleared", 32'(fault_flag), 0);
        go(16'h0600);

        // R8: time-out behaves the same
        rd_tmo = 1'b1;
        @(negedge clk);
        rd_tmo = 1'b0;
        check("R8 tmo req dropped", 32'(rd_req), 0);
        check("R8 tmo flag", 32'(fault_flag), 1);
        check("R8 tmo irq", 32'(fault_irq), 1);
        run_en = 1'b0;
        @(negedge clk);
        check("R9 tmo flag cleared", 32'(fault_flag), 0);
        check("R9 irq low", 32'(fault_irq), 0);
        go(16'h0600);
        xfer("R9 restart", 16'h0600, 1'b0);
        stop_drain(16'h0602, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule